// File: doc/BRIEF.md
# Sixteen-Pin I/O Bank with Pin Interrupts

This block is one bank of general-purpose pins that software controls through word-aligned registers on a simple bus. The bus has an address, a write strobe, write data and read data. Each pin is either driven by the bank or read by it. Output pins normally drive a programmed value. While the sleep input is high they drive a sleep value instead, and while the battery-fault input is high they drive a fault value. A per-pin select word is passed straight out, so that pads can be handed to other peripherals.

Every pin goes through a two-flop synchronizer. Each pin can then flag an event on a rising edge, a falling edge, a high level or a low level. Flagged events are held in a status register, and software clears a bit by writing a 1 to it. The bank raises one combined interrupt output whenever a pending bit is not masked. The sleep mask takes the place of the normal mask while the sleep input is high.

Top module: `gpio_bank_irq`

## Requirements
- R1: Registers sit at byte addresses 0x00 mask, 0x04 direction, 0x08 output value, 0x0C trigger kind, 0x10 edge polarity, 0x14 level polarity, 0x18 sleep mask, 0x1C sleep output value, 0x20 fault output value, 0x24 event status, 0x28 alternate select, 0x2C sleep config (plain read/write storage) and 0x30 pin levels. Any other address, or any address whose two low bits are not zero, reads as 0 and ignores writes. `bus_rdata` is registered: it shows the register addressed in the previous cycle.
- R2: `pin_oe` bit n is direction bit n, registered by one cycle (1 = output, 0 = input).
- R3: When trigger-kind bit n is 1, an edge on synchronized pin n sets status bit n: a rising edge if edge-polarity bit n is 1, a falling edge if it is 0.
- R4: When trigger-kind bit n is 0, status bit n is set on every cycle that synchronized pin n equals level-polarity bit n (1 = high, 0 = low).
- R5: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A detection in the same cycle as the clear keeps the bit set.
- R6: `irq_out` is a registered OR of the status bits whose active mask bit is 0.
- R7: While `sleep_in` is 1, the sleep mask replaces the normal mask for `irq_out`.
- R8: `pin_out` is registered. It takes the fault value while `bfault_in` is 1, otherwise the sleep value while `sleep_in` is 1, otherwise the output value. The fault input wins when both are high.
- R9: Address 0x30 returns the pin levels after a two-flop synchronizer, and writes to it have no effect.
- R10: `alt_sel` shows the alternate-select register.
- R11: Synchronous reset clears every register and output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address of register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| sleep_in | input | 1 | Sleep mode request |
| bfault_in | input | 1 | Battery fault indication |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Pin drive values |
| pin_oe | output | 16 | Pin output enables |
| alt_sel | output | 16 | Per-pin alternate function select |
| irq_out | output | 1 | Combined bank interrupt |

## Verification
The assertions check on every cycle that the fault and sleep overrides reach `pin_out`, and that `pin_oe` follows the direction bits. They also check that every detection lands in status even when it collides with a clear, that a clear without a detection empties the bit, and that `irq_out` never rises without an unmasked pending bit. Only the bench's scenarios can show that each trigger kind and polarity reacts to the right stimulus with the right synchronizer latency. The same holds for the register map and readback, the mask swap in sleep, and the fault-over-sleep priority. Long runs of pseudo-random pins, mode inputs and bus writes are checked against a reference model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 6;
  localparam int IDX_W  = 4;
  localparam int NSLOT  = 12;

  typedef enum logic [IDX_W-1:0] {
    IDX_MASK  = 4'd0,
    IDX_DIR   = 4'd1,
    IDX_OUT   = 4'd2,
    IDX_TRIG  = 4'd3,
    IDX_EDGE  = 4'd4,
    IDX_LEVEL = 4'd5,
    IDX_SMASK = 4'd6,
    IDX_SOUT  = 4'd7,
    IDX_BFOUT = 4'd8,
    IDX_STAT  = 4'd9,
    IDX_ALT   = 4'd10,
    IDX_SCFG  = 4'd11,
    IDX_PIN   = 4'd12
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      d_sync <= '0;
    end else begin
      meta_q <= d_in;
      d_sync <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] trig_edge,
  input  logic [W-1:0] edge_rise,
  input  logic [W-1:0] lvl_high,
  input  logic [W-1:0] clr,
  output logic [W-1:0] stat_q
);
  logic [W-1:0] prev_q;
  logic [W-1:0] det;

  for (genvar i = 0; i < W; i++) begin : g_det
    logic rise_i, fall_i, lvl_i;
    assign rise_i = pin_s[i] & ~prev_q[i];
    assign fall_i = ~pin_s[i] & prev_q[i];
    assign lvl_i  = ~(pin_s[i] ^ lvl_high[i]);
    assign det[i] = trig_edge[i] ? (edge_rise[i] ? rise_i : fall_i) : lvl_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= pin_s;
      stat_q <= (stat_q & ~clr) | det;
    end
  end

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(det)) == $past(det)));

  assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(clr & ~det)) == '0));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sleep,
  input  logic         bfault,
  input  logic [W-1:0] run_val,
  input  logic [W-1:0] sleep_val,
  input  logic [W-1:0] fault_val,
  input  logic [W-1:0] dir,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else begin
      pin_oe <= dir;
      if (bfault)     pin_out <= fault_val;
      else if (sleep) pin_out <= sleep_val;
      else            pin_out <= run_val;
    end
  end

  assert_fault_drive_R8: assert property (@(posedge clk) disable iff (rst)
    bfault |=> pin_out == $past(fault_val));

  assert_sleep_drive_R8: assert property (@(posedge clk) disable iff (rst)
    (sleep && !bfault) |=> pin_out == $past(sleep_val));

  assert_oe_follow_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pin_oe == $past(dir));
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic              sleep_in,
  input  logic              bfault_in,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  alt_sel,
  output logic              irq_out
);
  logic [NPINS-1:0] cfg_q [NSLOT];
  logic [NPINS-1:0] pin_s, stat, clr, mask_eff, rd_next;
  logic [IDX_W-1:0] idx;
  logic             aligned, wr_hit;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_hit  = bus_we && aligned;
  assign clr     = (wr_hit && idx == IDX_STAT) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLOT; i++) cfg_q[i] <= '0;
    end else if (wr_hit && idx < IDX_W'(NSLOT) && idx != IDX_STAT) begin
      cfg_q[idx] <= bus_wdata;
    end
  end

  gpio_sync2 #(.W(NPINS)) u_sync (
    .clk(clk), .rst(rst), .d_in(pin_in), .d_sync(pin_s)
  );

  gpio_irq_unit #(.W(NPINS)) u_irq (
    .clk(clk), .rst(rst), .pin_s(pin_s),
    .trig_edge(cfg_q[IDX_TRIG]), .edge_rise(cfg_q[IDX_EDGE]),
    .lvl_high(cfg_q[IDX_LEVEL]), .clr(clr), .stat_q(stat)
  );

  gpio_pad_mux #(.W(NPINS)) u_pad (
    .clk(clk), .rst(rst), .sleep(sleep_in), .bfault(bfault_in),
    .run_val(cfg_q[IDX_OUT]), .sleep_val(cfg_q[IDX_SOUT]),
    .fault_val(cfg_q[IDX_BFOUT]), .dir(cfg_q[IDX_DIR]),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign mask_eff = sleep_in ? cfg_q[IDX_SMASK] : cfg_q[IDX_MASK];
  assign alt_sel  = cfg_q[IDX_ALT];

  always_comb begin
    rd_next = '0;
    if (aligned) begin
      if (idx == IDX_STAT)                rd_next = stat;
      else if (idx == IDX_PIN)            rd_next = pin_s;
      else if (idx < IDX_W'(NSLOT))       rd_next = cfg_q[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      bus_rdata <= rd_next;
      irq_out   <= |(stat & ~mask_eff);
    end
  end

  assert_irq_has_source_R6: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (($past(stat) & ~$past(mask_eff)) != '0));
endmodule

// File: tb/tb_gpio_bank_irq.sv
module tb_gpio_bank_irq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        sleep_in = 1'b0;
  logic        bfault_in = 1'b0;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe, alt_sel;
  logic        irq_out;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_bank_irq dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_in(sleep_in),
    .bfault_in(bfault_in), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .alt_sel(alt_sel), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: behavioural, per pin, from the requirements
  logic [15:0] m_reg [16];
  logic [15:0] m_s1, m_s2, m_prev, m_stat, m_out, m_oe, m_rd;
  logic        m_irq;

  always @(posedge clk) begin
    logic [15:0] d, c, msk;
    int ix;
    if (rst) begin
      for (int k = 0; k < 16; k++) m_reg[k] <= '0;
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_stat <= '0;
      m_out <= '0; m_oe <= '0; m_rd <= '0; m_irq <= 1'b0;
    end else begin
      for (int b = 0; b < 16; b++) begin
        if (m_reg[3][b])
          d[b] = m_reg[4][b] ? (m_s2[b] && !m_prev[b]) : (!m_s2[b] && m_prev[b]);
        else
          d[b] = (m_s2[b] == m_reg[5][b]);
      end
      ix = int'(bus_addr[5:2]);
      c = '0;
      if (bus_we && bus_addr[1:0] == 2'b00) begin
        if (ix == 9) c = bus_wdata;
        else if (ix < 12) m_reg[ix] <= bus_wdata;
      end
      m_stat <= (m_stat & ~c) | d;
      msk = sleep_in ? m_reg[6] : m_reg[0];
      m_irq <= ((m_stat & ~msk) != 0);
      m_out <= bfault_in ? m_reg[8] : (sleep_in ? m_reg[7] : m_reg[2]);
      m_oe <= m_reg[1];
      m_s1 <= pin_in; m_s2 <= m_s1; m_prev <= m_s2;
      if (bus_addr[1:0] != 2'b00) m_rd <= '0;
      else if (ix == 9) m_rd <= m_stat;
      else if (ix == 12) m_rd <= m_s2;
      else if (ix < 12) m_rd <= m_reg[ix];
      else m_rd <= '0;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk("R1 rdata vs model", bus_rdata, m_rd);
      chk("R8 pin_out vs model", pin_out, m_out);
      chk("R2 pin_oe vs model", pin_oe, m_oe);
      chk("R10 alt_sel vs model", alt_sel, m_reg[10]);
      chk("R6 irq_out vs model", {15'd0, irq_out}, {15'd0, m_irq});
    end
  end

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); bus_addr = a; bus_we = 1'b0;
    @(negedge clk); chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    chk("R11 pin_out in reset", pin_out, 16'h0);
    chk("R11 irq in reset", {15'd0, irq_out}, 16'h0);
    chk("R11 rdata in reset", bus_rdata, 16'h0);
    rst = 1'b0;
    rd(6'h08, 16'h0, "R11 output reg after reset");

    // R1 register map readback
    for (int i = 0; i < 12; i++) begin
      if (i != 9) wr(6'(i * 4), 16'hA5C3 ^ 16'(i * 16'h0101));
    end
    for (int i = 0; i < 12; i++) begin
      if (i != 9) rd(6'(i * 4), 16'hA5C3 ^ 16'(i * 16'h0101), "R1 readback");
    end
    rd(6'h34, 16'h0, "R1 unmapped address");
    wr(6'h09, 16'hFFFF);
    rd(6'h08, 16'hA5C3 ^ 16'h0202, "R1 misaligned write ignored");
    rd(6'h09, 16'h0, "R1 misaligned read");
    for (int i = 0; i < 12; i++) if (i != 9) wr(6'(i * 4), 16'h0);

    // R3 edges
    wr(6'h0C, 16'hFFFF); wr(6'h10, 16'hFFFF);
    idle(4); wr(6'h24, 16'hFFFF);
    rd(6'h24, 16'h0, "R5 status cleared");
    @(negedge clk) pin_in = 16'h0008;
    idle(4);
    rd(6'h24, 16'h0008, "R3 rising edge");
    wr(6'h24, 16'h0008);
    rd(6'h24, 16'h0, "R5 single bit clear");
    wr(6'h10, 16'h0000);
    @(negedge clk) pin_in = 16'h0000;
    idle(4);
    rd(6'h24, 16'h0008, "R3 falling edge");
    wr(6'h24, 16'hFFFF);

    // R4 levels
    wr(6'h14, 16'hFFFF); wr(6'h0C, 16'h0000);
    @(negedge clk) pin_in = 16'h0010;
    idle(4);
    rd(6'h24, 16'h0010, "R4 high level");
    wr(6'h24, 16'hFFFF);
    rd(6'h24, 16'h0010, "R5 detect beats clear");
    @(negedge clk) pin_in = 16'h0000;
    idle(4); wr(6'h24, 16'hFFFF);
    rd(6'h24, 16'h0, "R4 low ignored when high selected");

    // R6 / R7 masking
    @(negedge clk) pin_in = 16'h0010;
    idle(5);
    chk("R6 unmasked irq", {15'd0, irq_out}, 16'h1);
    wr(6'h00, 16'h0010); idle(2);
    chk("R6 masked irq", {15'd0, irq_out}, 16'h0);
    @(negedge clk) sleep_in = 1'b1; idle(2);
    chk("R7 sleep mask open", {15'd0, irq_out}, 16'h1);
    wr(6'h18, 16'hFFFF); idle(2);
    chk("R7 sleep mask closed", {15'd0, irq_out}, 16'h0);
    @(negedge clk) sleep_in = 1'b0; wr(6'h00, 16'h0); idle(2);
    chk("R7 normal mask back", {15'd0, irq_out}, 16'h1);

    // R8 / R2 outputs
    wr(6'h08, 16'h00A5); wr(6'h1C, 16'h0F0F); wr(6'h20, 16'h3C3C); wr(6'h04, 16'h00FF);
    idle(2);
    chk("R8 run value", pin_out, 16'h00A5);
    chk("R2 direction", pin_oe, 16'h00FF);
    @(negedge clk) sleep_in = 1'b1; idle(2);
    chk("R8 sleep value", pin_out, 16'h0F0F);
    @(negedge clk) bfault_in = 1'b1; idle(2);
    chk("R8 fault over sleep", pin_out, 16'h3C3C);
    @(negedge clk) sleep_in = 1'b0; idle(2);
    chk("R8 fault alone", pin_out, 16'h3C3C);
    @(negedge clk) bfault_in = 1'b0; idle(2);
    chk("R8 back to run value", pin_out, 16'h00A5);

    // R9 / R10
    @(negedge clk) pin_in = 16'h1234; idle(3);
    rd(6'h30, 16'h1234, "R9 pin levels");
    wr(6'h30, 16'hFFFF);
    rd(6'h30, 16'h1234, "R9 write ignored");
    wr(6'h28, 16'h8001);
    chk("R10 alt select", alt_sel, 16'h8001);

    // pseudo-random run against the model
    lf = 32'hC0FFEE11;
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      pin_in = lf[15:0] ^ lf[31:16];
      sleep_in = (lf[7:4] == 4'h3) ? ~sleep_in : sleep_in;
      bfault_in = (lf[11:8] == 4'h5) ? ~bfault_in : bfault_in;
      bus_we = lf[2];
      bus_addr = (lf[9:8] == 2'b11) ? lf[29:24] : {lf[27:24], 2'b00};
      bus_wdata = lf[31:16] ^ lf[23:8];
    end
    @(negedge clk) bus_we = 1'b0;
    idle(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule